// File: doc/BRIEF.md
# Counter-Mode Block Cipher Wrapper

This block turns an external encrypt-only 128-bit block cipher into a counter-mode stream processor. Software first loads a 128-bit counter block. The low 32-bit word of that block is a running counter and the upper 96 bits are a fixed nonce. For each incoming data block, the wrapper offers the current counter block to the cipher port. It then takes back the keystream, XORs it with the data block and hands the result to a consumer. The input and output data are word-swapped according to a 2-bit data-type code.

Encryption and decryption are the same operation, so the block has no direction input. Passing ciphertext through with the same starting counter block gives back the plaintext. Only one block is in flight at a time.

A four-state machine sequences each block:
- **ST_IDLE** accepts a data block or a counter-block load.
- **ST_REQ** offers the counter block to the cipher.
- **ST_WAIT** waits for the keystream.
- **ST_OUT** presents the result.

The transitions are:
- ST_IDLE→ST_REQ on the data-in handshake.
- ST_REQ→ST_WAIT on the cipher request handshake.
- ST_WAIT→ST_OUT on the keystream handshake.
- ST_OUT→ST_IDLE on the data-out handshake.

Top module: `ctr_stream_xcore`

## Requirements
- R1: Once a block is accepted, `out_data` equals SWP(SWP(in_data, dt) XOR ks), where dt is the `dtype` value sampled with the block and ks is `ks_rsp_data`. The keystream itself is never swapped.
- R2: The cipher request `ks_req_block` always carries the current counter block, whatever the data. Feeding an output block back in with the same starting counter block therefore returns the original input block.
- R3: `cfg_we` in ST_IDLE replaces the whole counter block with `cfg_block`. Bits [31:0] are the counter and bits [127:32] are the nonce.
- R4: The counter increments by one on each data-out handshake, and at no other time. Nonce bits [127:32] never change except by a load.
- R5: A counter of 0xFFFFFFFF increments to 0x00000000 with no carry into bit 32.
- R6: Data-type swap on each 32-bit word w:
  - 2'b00 leaves w unchanged.
  - 2'b01 gives {w[15:0], w[31:16]}.
  - 2'b10 reverses the byte order.
  - 2'b11 reverses the bit order.
- R7: At most one block is in flight. `in_ready` is high only in ST_IDLE, and a held output (`out_valid` with `out_ready` low) keeps `in_ready` low.
- R8: While a request or output is stalled, `ks_req_block` and `out_data` respectively hold their value, with the valid still high.
- R9: A `cfg_we` pulse while a block is in flight leaves the counter block unchanged.
- R10: A synchronous active-low reset clears the counter block to zero, returns to ST_IDLE and drops `out_valid` and `ks_req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the counter block |
| cfg_block | input | 128 | New counter block (nonce in [127:32], counter in [31:0]) |
| dtype | input | 2 | Data-type swap code, sampled with each block |
| in_valid | input | 1 | Data block offered |
| in_ready | output | 1 | Data block can be taken |
| in_data | input | 128 | Plaintext or ciphertext block |
| ks_req_valid | output | 1 | Counter block offered to cipher |
| ks_req_ready | input | 1 | Cipher takes the counter block |
| ks_req_block | output | 128 | Current counter block |
| ks_rsp_valid | input | 1 | Keystream available |
| ks_rsp_ready | output | 1 | Wrapper waits for keystream |
| ks_rsp_data | input | 128 | Keystream block |
| out_valid | output | 1 | Result block offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Result block |

## Verification
The counter wrap is the hardest case to reach from the ports, since 2^32 blocks cannot be run. The bench instead loads a counter of 0xFFFFFFFE under a distinctive nonce and streams three blocks, checking each request word and that the nonce stays intact. The in-flight load that must be ignored is forced by pulsing the load strobe while the stub cipher or the consumer is deliberately stalled.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    typedef enum logic [1:0] {
        DT_NONE = 2'b00,
        DT_HALF = 2'b01,
        DT_BYTE = 2'b10,
        DT_BIT  = 2'b11
    } dtype_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_REQ  = 2'b01,
        ST_WAIT = 2'b10,
        ST_OUT  = 2'b11
    } ctr_state_e;
endpackage

// File: rtl/ctr_swap.sv
module ctr_swap
    import ctr_pkg::*;
#(
    parameter int BLK_W  = 128,
    parameter int WORD_W = 32
) (
    input  dtype_e             mode,
    input  logic [BLK_W-1:0]   din,
    output logic [BLK_W-1:0]   dout
);
    localparam int NW   = BLK_W / WORD_W;
    localparam int HALF = WORD_W / 2;
    localparam int NB   = WORD_W / 8;

    for (genvar g = 0; g < NW; g++) begin : g_word
        logic [WORD_W-1:0] w, half_s, byte_s, bit_s, sel;

        assign w      = din[g*WORD_W +: WORD_W];
        assign half_s = {w[HALF-1:0], w[WORD_W-1:HALF]};

        always_comb begin
            for (int b = 0; b < NB; b++)
                byte_s[b*8 +: 8] = w[(NB-1-b)*8 +: 8];
        end

        always_comb begin
            for (int i = 0; i < WORD_W; i++)
                bit_s[i] = w[WORD_W-1-i];
        end

        always_comb begin
            unique case (mode)
                DT_NONE: sel = w;
                DT_HALF: sel = half_s;
                DT_BYTE: sel = byte_s;
                DT_BIT:  sel = bit_s;
            endcase
        end

        assign dout[g*WORD_W +: WORD_W] = sel;
    end
endmodule

// File: rtl/ctr_cnt_reg.sv
module ctr_cnt_reg #(
    parameter int BLK_W = 128,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BLK_W-1:0] load_val,
    input  logic             bump,
    output logic [BLK_W-1:0] blk
);
    localparam int NONCE_W = BLK_W - CNT_W;

    logic [NONCE_W-1:0] nonce_q;
    logic [CNT_W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nonce_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            nonce_q <= load_val[BLK_W-1:CNT_W];
            cnt_q   <= load_val[CNT_W-1:0];
        end else if (bump) begin
            cnt_q   <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    assign blk = {nonce_q, cnt_q};
endmodule

// File: rtl/ctr_stream_xcore.sv
module ctr_stream_xcore
    import ctr_pkg::*;
#(
    parameter int BLK_W  = 128,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [BLK_W-1:0] cfg_block,
    input  logic [1:0]       dtype,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [BLK_W-1:0] in_data,
    output logic             ks_req_valid,
    input  logic             ks_req_ready,
    output logic [BLK_W-1:0] ks_req_block,
    input  logic             ks_rsp_valid,
    output logic             ks_rsp_ready,
    input  logic [BLK_W-1:0] ks_rsp_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BLK_W-1:0] out_data
);
    ctr_state_e state_q, state_d;

    logic [BLK_W-1:0] din_sw, din_q, mix, mix_sw, out_q;
    dtype_e           dt_q;
    logic             take_in, take_cfg, take_out;

    // ---- state register ----
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---- next state ----
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)     state_d = ST_REQ;
            ST_REQ:  if (ks_req_ready) state_d = ST_WAIT;
            ST_WAIT: if (ks_rsp_valid) state_d = ST_OUT;
            ST_OUT:  if (out_ready)    state_d = ST_IDLE;
        endcase
    end

    // ---- state outputs ----
    always_comb begin
        in_ready     = 1'b0;
        ks_req_valid = 1'b0;
        ks_rsp_ready = 1'b0;
        out_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready     = 1'b1;
            ST_REQ:  ks_req_valid = 1'b1;
            ST_WAIT: ks_rsp_ready = 1'b1;
            ST_OUT:  out_valid    = 1'b1;
        endcase
    end

    assign take_in  = in_ready && in_valid;
    assign take_cfg = in_ready && cfg_we;
    assign take_out = out_valid && out_ready;

    ctr_swap #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_swap_in (
        .mode (dtype_e'(dtype)),
        .din  (in_data),
        .dout (din_sw)
    );

    assign mix = din_q ^ ks_rsp_data;

    ctr_swap #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_swap_out (
        .mode (dt_q),
        .din  (mix),
        .dout (mix_sw)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= '0;
            dt_q  <= DT_NONE;
            out_q <= '0;
        end else begin
            if (take_in) begin
                din_q <= din_sw;
                dt_q  <= dtype_e'(dtype);
            end
            if (ks_rsp_ready && ks_rsp_valid)
                out_q <= mix_sw;
        end
    end

    ctr_cnt_reg #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_cfg),
        .load_val (cfg_block),
        .bump     (take_out),
        .blk      (ks_req_block)
    );

    assign out_data = out_q;
endmodule

// File: rtl/ctr_stream_xcore_chk.sv
module ctr_stream_xcore_chk #(
    parameter int BLK_W = 128,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             ks_req_valid,
    input logic             ks_req_ready,
    input logic [BLK_W-1:0] ks_req_block,
    input logic             ks_rsp_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BLK_W-1:0] out_data
);
    p_one_flight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_ready, ks_req_valid, ks_rsp_ready, out_valid}));

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ks_req_valid && !ks_req_ready |=> ks_req_valid && $stable(ks_req_block));

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=>
            ks_req_block[CNT_W-1:0] == $past(ks_req_block[CNT_W-1:0]) + 1'b1
            && $stable(ks_req_block[BLK_W-1:CNT_W]));

    p_busy_nochg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready && !(out_valid && out_ready) |=> $stable(ks_req_block));

    p_reset_clr_r10: assert property (@(posedge clk)
        !rst_n |=> ks_req_block == '0 && !out_valid && !ks_req_valid && in_ready);
endmodule

bind ctr_stream_xcore ctr_stream_xcore_chk #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_ctr_stream_xcore.sv
module sim_ctr_stream_xcore;
    logic         clk = 1'b0;
    logic         rst_n, cfg_we, in_valid, ks_req_ready, ks_rsp_valid, out_ready;
    logic [127:0] cfg_block, in_data, ks_rsp_data;
    logic [1:0]   dtype;
    wire          in_ready, ks_req_valid, ks_rsp_ready, out_valid;
    wire  [127:0] ks_req_block, out_data;

    always #2.5 clk = ~clk;

    ctr_stream_xcore u0 (.*);

    int           n_cmp = 0, n_bad = 0;
    int           stub_dly = 0;
    logic [127:0] last_req, exp_blk;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [127:0] stub_f(input logic [127:0] b);
        logic [31:0] m = b[31:0] * 32'h9E3779B1;
        return {b[95:0], b[127:96]} ^ 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0
               ^ {m, ~m, m ^ 32'h5555_AAAA, m};
    endfunction

    function automatic logic [127:0] swp(input logic [127:0] d, input logic [1:0] t);
        logic [127:0] r;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] w = d[k*32 +: 32];
            logic [31:0] o = 0;
            case (t)
                2'd0: o = w;
                2'd1: o = (w << 16) | (w >> 16);
                2'd2: o = {w[7:0], w[15:8], w[23:16], w[31:24]};
                default: for (int i = 0; i < 32; i++) o[31-i] = w[i];
            endcase
            r[k*32 +: 32] = o;
        end
        return r;
    endfunction

    // stub cipher
    initial begin
        ks_req_ready = 0; ks_rsp_valid = 0; ks_rsp_data = '0;
        forever begin
            @(negedge clk);
            if (ks_req_valid) begin
                repeat (stub_dly) @(negedge clk);
                last_req = ks_req_block;
                ks_req_ready = 1;
                @(negedge clk); ks_req_ready = 0;
                repeat (stub_dly) @(negedge clk);
                ks_rsp_valid = 1; ks_rsp_data = stub_f(last_req);
                @(negedge clk); ks_rsp_valid = 0;
            end
        end
    end

    task automatic load(input logic [127:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        cfg_we = 1; cfg_block = b;
        @(negedge clk); cfg_we = 0;
        exp_blk = b;
        chk("R3 load", ks_req_block, b);
    endtask

    task automatic run_blk(input logic [127:0] d, input logic [1:0] dt, input int stall,
                           input bit busy_wr, output logic [127:0] got);
        logic [127:0] exp, first;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_data = d; dtype = dt;
        @(negedge clk); in_valid = 0; dtype = ~dt;
        if (busy_wr) begin
            cfg_we = 1; cfg_block = ~exp_blk;
            @(negedge clk); cfg_we = 0;
        end
        while (!out_valid) @(negedge clk);
        exp = swp(swp(d, dt) ^ stub_f(exp_blk), dt);
        first = out_data;
        for (int k = 0; k < stall; k++) begin
            chk("R7 in_ready low while held", {127'd0, in_ready}, 128'd0);
            if (busy_wr && k == 0) begin
                cfg_we = 1; cfg_block = ~exp_blk;
            end
            @(negedge clk);
            cfg_we = 0;
            chk("R8 out held", out_data, first);
            chk("R9 block unchanged", ks_req_block, exp_blk);
        end
        chk("R1/R6 out_data", out_data, exp);
        chk("R2/R4 req block", last_req, exp_blk);
        out_ready = 1; got = out_data;
        @(negedge clk); out_ready = 0;
        exp_blk[31:0] = exp_blk[31:0] + 32'd1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        logic [127:0] got, ct;
        logic [127:0] pats [4];
        pats[0] = 128'h0;
        pats[1] = 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF;
        pats[2] = 128'h00112233_44556677_8899AABB_CCDDEEFF;
        pats[3] = 128'h80000001_0000FFFF_12345678_F00DCAFE;
        rst_n = 0; cfg_we = 0; cfg_block = '0; dtype = 0;
        in_valid = 0; in_data = '0; out_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10 reset block", ks_req_block, '0);
        chk("R10 reset valids", {125'd0, in_ready, out_valid, ks_req_valid}, {125'd0, 3'b100});

        // R6 sweep of swap modes, data patterns, stub delays and stalls
        load(128'hCAFEBABE_DEADBEEF_01234567_00000001);
        for (int t = 0; t < 4; t++)
            for (int p = 0; p < 4; p++) begin
                stub_dly = (t + p) % 3;
                run_blk(pats[p] ^ {4{t[31:0]}}, t[1:0], p % 3, 1'b0, got);
            end

        // R2 decryption equals encryption
        for (int t = 0; t < 4; t++) begin
            load(128'h11111111_22222222_33333333_00000001);
            run_blk(pats[2], t[1:0], 0, 1'b0, ct);
            load(128'h11111111_22222222_33333333_00000001);
            run_blk(ct, t[1:0], 1, 1'b0, got);
            chk("R2 round trip", got, pats[2]);
        end

        // R5 wrap with no carry into nonce
        load(128'hA5A5A5A5_5A5A5A5A_F0F0F0F0_FFFFFFFE);
        stub_dly = 1;
        for (int i = 0; i < 3; i++) run_blk(pats[3], 2'd1, 0, 1'b0, got);
        chk("R5 wrapped block", ks_req_block, 128'hA5A5A5A5_5A5A5A5A_F0F0F0F0_00000001);

        // R9 loads while busy are ignored
        stub_dly = 2;
        for (int i = 0; i < 3; i++) run_blk(pats[i], 2'd2, 2, 1'b1, got);

        // R10 reset mid-stream state
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R10 reset clears block", ks_req_block, '0);

        summary();
        $finish;
    end
endmodule